// File: doc/BRIEF.md
# Single-Precision Compare and Min/Max Unit

This unit evaluates one single-precision floating-point operation per accepted request. The operation is chosen by a 3-bit opcode. The compare operations are less-than and less-or-equal, each in a signaling and a quiet form, and a quiet equality test. The selection operations are minimum and maximum. Each operand arrives as a 64-bit floating-point register value, and the single-precision number sits in its low 32 bits.

When double-precision support is configured, a register whose upper half is not all ones does not hold a properly boxed single-precision value. Such an operand is replaced by the canonical quiet NaN before any decision is made.

Results are registered, so they appear one cycle after the request. A compare result occupies bit 0 of an integer-width output. A selected min/max value appears on a separate 32-bit output. The invalid-operation flag is valid in the same cycle as the result.

Top module: `fpcmp_unit`

## Requirements
- R1: When `valid_in` is high on a clock edge, `valid_out` is high after that edge, and low otherwise. While `valid_out` is low, `cmp_res`, `mm_res` and `invalid` are all zero. Reset clears every output.
- R2: With `BOX_CHECK`=1, an operand whose bits 63:32 are not all ones is used as the canonical NaN 0x7FC00000, which is a quiet NaN.
- R3: A value is a NaN when bits 30:23 are all ones and bits 22:0 are not zero. A NaN is signaling when bit 22 is 0, and quiet when bit 22 is 1.
- R4: The opcode encodings are: 0 signaling less-than, 1 signaling less-or-equal, 2 quiet equal, 3 quiet less-than, 4 quiet less-or-equal, 5 minimum, 6 maximum. Code 7 yields all-zero results and no flag.
- R5: Signaling less-than and less-or-equal return 0 and raise `invalid` if either operand is any NaN.
- R6: Quiet less-than, quiet less-or-equal and equal return 0 if either operand is a NaN. They raise `invalid` only if a NaN operand is signaling.
- R7: For non-NaN compare operands, +0 and -0 are equal and neither is less than the other. With differing signs, a is less than b exactly when a is negative. With equal signs, the order follows the magnitude, reversed for negative values.
- R8: Compare results sit in bit 0 of `cmp_res` with all upper bits zero, and `mm_res` is zero for compare opcodes. For min/max opcodes, `cmp_res` is zero.
- R9: For min/max, two NaN operands give 0x7FC00000, and a single NaN gives the other operand. `invalid` rises only when a signaling NaN is present.
- R10: For min/max, -0 is ordered below +0. Minimum of a mixed zero pair gives 0x80000000, and maximum gives 0x00000000.
- R11: For non-NaN min/max operands, minimum returns the smaller value and maximum returns the larger, with infinities ordered at the ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| valid_in | input | 1 | Request strobe |
| op_i | input | 3 | Operation select |
| opa_i | input | REG_W | First register operand |
| opb_i | input | REG_W | Second register operand |
| valid_out | output | 1 | Result strobe, one cycle after the request |
| cmp_res | output | XLEN | Zero-extended compare result |
| mm_res | output | 32 | Min/max selected value |
| invalid | output | 1 | Invalid-operation flag |

## Verification
The bench builds the unit with its defaults: 64-bit registers, a 64-bit integer result and `BOX_CHECK`=1. With box checking enabled, operands whose upper halves are malformed become reachable stimulus, and the substituted canonical NaN can be observed at both outputs. The full 64-bit result width makes a stray upper bit in the zero-extension visible. Every opcode, including the unused code, is crossed with a set of special values. These are signed zeros, infinities, quiet and signaling NaNs, subnormals and the largest finite value. Random operand pairs with mixed boxing follow.

// File: rtl/fpcmp_pkg.sv
package fpcmp_pkg;
    localparam int SP_W  = 32;
    localparam int EXP_W = 8;
    localparam int MAN_W = 23;
    localparam logic [SP_W-1:0] CANON_NAN = 32'h7FC0_0000;

    typedef enum logic [2:0] {
        OP_LT_S = 3'd0,
        OP_LE_S = 3'd1,
        OP_EQ   = 3'd2,
        OP_LT_Q = 3'd3,
        OP_LE_Q = 3'd4,
        OP_MIN  = 3'd5,
        OP_MAX  = 3'd6,
        OP_NONE = 3'd7
    } fp_op_e;

    typedef struct packed {
        logic nan;
        logic snan;
        logic zero;
    } fp_class_t;
endpackage

// File: rtl/fpcmp_unbox.sv
module fpcmp_unbox #(
    parameter int REG_W     = 64,
    parameter int SP_W      = 32,
    parameter bit BOX_CHECK = 1'b1,
    parameter logic [SP_W-1:0] CANON = 32'h7FC0_0000
) (
    input  logic [REG_W-1:0] reg_i,
    output logic [SP_W-1:0]  sp_o
);
    localparam int HI_W = REG_W - SP_W;

    generate
        if (BOX_CHECK && HI_W > 0) begin : g_check
            logic boxed_ok;
            assign boxed_ok = (reg_i[REG_W-1:SP_W] == {HI_W{1'b1}});
            assign sp_o     = boxed_ok ? reg_i[SP_W-1:0] : CANON;
        end else begin : g_pass
            assign sp_o = reg_i[SP_W-1:0];
        end
    endgenerate
endmodule

// File: rtl/fpcmp_classify.sv
module fpcmp_classify
    import fpcmp_pkg::*;
#(
    parameter int W  = 32,
    parameter int EW = 8,
    parameter int MW = 23
) (
    input  logic [W-1:0] val_i,
    output fp_class_t    cls_o
);
    logic [EW-1:0] expo;
    logic [MW-1:0] mant;

    always_comb begin
        expo        = val_i[W-2 -: EW];
        mant        = val_i[MW-1:0];
        cls_o.nan   = (expo == {EW{1'b1}}) && (mant != '0);
        cls_o.snan  = cls_o.nan && !mant[MW-1];
        cls_o.zero  = (val_i[W-2:0] == '0);
    end
endmodule

// File: rtl/fpcmp_order.sv
module fpcmp_order
    import fpcmp_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  fp_class_t    ca_i,
    input  fp_class_t    cb_i,
    output logic         lt_cmp_o,
    output logic         eq_cmp_o,
    output logic         lt_mm_o
);
    logic sa, sb, mag_lt, differ, same_sign_lt;

    always_comb begin
        sa           = a_i[W-1];
        sb           = b_i[W-1];
        mag_lt       = (a_i < b_i);
        differ       = (a_i != b_i);
        same_sign_lt = differ && (sa ^ mag_lt);
        eq_cmp_o     = !differ || (ca_i.zero && cb_i.zero);
        if (sa != sb) begin
            lt_cmp_o = sa && !(ca_i.zero && cb_i.zero);
            lt_mm_o  = sa;
        end else begin
            lt_cmp_o = same_sign_lt;
            lt_mm_o  = same_sign_lt;
        end
    end
endmodule

// File: rtl/fpcmp_unit.sv
module fpcmp_unit
    import fpcmp_pkg::*;
#(
    parameter int REG_W     = 64,
    parameter int XLEN      = 64,
    parameter bit BOX_CHECK = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valid_in,
    input  logic [2:0]       op_i,
    input  logic [REG_W-1:0] opa_i,
    input  logic [REG_W-1:0] opb_i,
    output logic             valid_out,
    output logic [XLEN-1:0]  cmp_res,
    output logic [SP_W-1:0]  mm_res,
    output logic             invalid
);
    localparam int N_OPND = 2;

    typedef struct packed {
        logic            valid;
        logic            res;
        logic [SP_W-1:0] mm;
        logic            inv;
    } out_st_t;

    logic [N_OPND-1:0][REG_W-1:0] reg_in;
    logic [N_OPND-1:0][SP_W-1:0]  sp;
    fp_class_t [N_OPND-1:0]       cls;

    assign reg_in[0] = opa_i;
    assign reg_in[1] = opb_i;

    genvar gi;
    generate
        for (gi = 0; gi < N_OPND; gi++) begin : g_opnd
            fpcmp_unbox #(
                .REG_W(REG_W), .SP_W(SP_W), .BOX_CHECK(BOX_CHECK), .CANON(CANON_NAN)
            ) u_unbox (
                .reg_i(reg_in[gi]),
                .sp_o (sp[gi])
            );
            fpcmp_classify #(.W(SP_W), .EW(EXP_W), .MW(MAN_W)) u_cls (
                .val_i(sp[gi]),
                .cls_o(cls[gi])
            );
        end
    endgenerate

    logic lt_cmp, eq_cmp, lt_mm;

    fpcmp_order #(.W(SP_W)) u_order (
        .a_i     (sp[0]),
        .b_i     (sp[1]),
        .ca_i    (cls[0]),
        .cb_i    (cls[1]),
        .lt_cmp_o(lt_cmp),
        .eq_cmp_o(eq_cmp),
        .lt_mm_o (lt_mm)
    );

    out_st_t st_d, st_q;
    logic    any_nan, any_snan, both_nan;

    always_comb begin
        any_nan  = cls[0].nan || cls[1].nan;
        any_snan = cls[0].snan || cls[1].snan;
        both_nan = cls[0].nan && cls[1].nan;
        st_d     = '0;
        if (valid_in) begin
            st_d.valid = 1'b1;
            case (fp_op_e'(op_i))
                OP_LT_S: begin
                    st_d.inv = any_nan;
                    st_d.res = !any_nan && lt_cmp;
                end
                OP_LE_S: begin
                    st_d.inv = any_nan;
                    st_d.res = !any_nan && (lt_cmp || eq_cmp);
                end
                OP_EQ: begin
                    st_d.inv = any_snan;
                    st_d.res = !any_nan && eq_cmp;
                end
                OP_LT_Q: begin
                    st_d.inv = any_snan;
                    st_d.res = !any_nan && lt_cmp;
                end
                OP_LE_Q: begin
                    st_d.inv = any_snan;
                    st_d.res = !any_nan && (lt_cmp || eq_cmp);
                end
                OP_MIN, OP_MAX: begin
                    st_d.inv = any_snan;
                    if (both_nan)         st_d.mm = CANON_NAN;
                    else if (cls[0].nan)  st_d.mm = sp[1];
                    else if (cls[1].nan)  st_d.mm = sp[0];
                    else if (op_i == OP_MIN) st_d.mm = lt_mm ? sp[0] : sp[1];
                    else                  st_d.mm = lt_mm ? sp[1] : sp[0];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign valid_out = st_q.valid;
    assign cmp_res   = {{(XLEN-1){1'b0}}, st_q.res};
    assign mm_res    = st_q.mm;
    assign invalid   = st_q.inv;

    // Assertions
    p_valid_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
        valid_in |=> valid_out);
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_in |=> (!valid_out && cmp_res == '0 && mm_res == '0 && !invalid));
    p_unused_op_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_in && op_i == OP_NONE) |=> (cmp_res == '0 && mm_res == '0 && !invalid));
    p_sig_nan_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_in && (op_i == OP_LT_S || op_i == OP_LE_S) && (cls[0].nan || cls[1].nan))
        |=> (invalid && cmp_res == '0));
    p_lt_eq_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        valid_in |-> !(lt_cmp && eq_cmp));
    p_cmp_no_mm_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_in && op_i <= OP_LE_Q) |=> (mm_res == '0));
    p_mm_no_cmp_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_in && (op_i == OP_MIN || op_i == OP_MAX)) |=> (cmp_res == '0));
    p_mm_canon_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_in && (op_i == OP_MIN || op_i == OP_MAX) && cls[0].nan && cls[1].nan)
        |=> (mm_res == CANON_NAN));
endmodule

// File: tb/tb_fpcmp_unit.sv
module tb_fpcmp_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_in = 1'b0;
    logic [2:0]  op_i = 3'd0;
    logic [63:0] opa_i = 64'd0;
    logic [63:0] opb_i = 64'd0;
    logic        valid_out;
    logic [63:0] cmp_res;
    logic [31:0] mm_res;
    logic        invalid;

    always #5 clk = ~clk;

    fpcmp_unit dut (
        .clk(clk), .rst_n(rst_n), .valid_in(valid_in), .op_i(op_i),
        .opa_i(opa_i), .opb_i(opb_i), .valid_out(valid_out),
        .cmp_res(cmp_res), .mm_res(mm_res), .invalid(invalid)
    );

    typedef struct {
        logic        v;
        logic [63:0] r;
        logic [31:0] m;
        logic        inv;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done  = 0;

    localparam logic [31:0] QNAN_C = 32'h7FC0_0000;
    logic [31:0] specials [12] = '{32'h0000_0000, 32'h8000_0000, 32'h7F80_0000,
        32'hFF80_0000, 32'h7FC0_0001, 32'h7F80_0001, 32'h3F80_0000, 32'hBF80_0000,
        32'h4000_0000, 32'h0000_0001, 32'h8000_0001, 32'h7F7F_FFFF};

    function automatic logic [31:0] m_unbox(logic [63:0] r);
        return (r[63:32] == 32'hFFFF_FFFF) ? r[31:0] : QNAN_C;
    endfunction
    function automatic bit m_nan(logic [31:0] x);
        return (x[30:23] == 8'hFF) && (x[22:0] != 0);
    endfunction
    function automatic bit m_snan(logic [31:0] x);
        return m_nan(x) && !x[22];
    endfunction
    // Signed numeric key: both zeros map to 0 for compares.
    function automatic longint k_cmp(logic [31:0] x);
        longint mag = longint'(x[30:0]);
        return x[31] ? -mag : mag;
    endfunction
    // Min/max key: -0 sits one step below +0.
    function automatic longint k_mm(logic [31:0] x);
        longint mag = longint'(x[30:0]);
        return x[31] ? -mag - 1 : mag;
    endfunction

    function automatic exp_t model(logic v, logic [2:0] op, logic [63:0] ra, logic [63:0] rb);
        exp_t e;
        logic [31:0] a = m_unbox(ra);
        logic [31:0] b = m_unbox(rb);
        bit na = m_nan(a), nb = m_nan(b);
        bit sn = m_snan(a) || m_snan(b);
        bit boxed = (ra[63:32] == '1) && (rb[63:32] == '1);
        e.v = v; e.r = 0; e.m = 0; e.inv = 0;
        e.tag = boxed ? "R7" : "R2";
        if (!v) begin e.tag = "R1"; return e; end
        case (op)
            3'd0, 3'd1: begin
                if (na || nb) begin e.inv = 1; e.tag = boxed ? "R5" : "R2"; end
                else e.r = (op == 0) ? 64'(k_cmp(a) < k_cmp(b)) : 64'(k_cmp(a) <= k_cmp(b));
            end
            3'd2, 3'd3, 3'd4: begin
                if (na || nb) begin e.inv = sn; e.tag = boxed ? "R6 R3" : "R2"; end
                else if (op == 2) e.r = 64'(k_cmp(a) == k_cmp(b));
                else if (op == 3) e.r = 64'(k_cmp(a) < k_cmp(b));
                else e.r = 64'(k_cmp(a) <= k_cmp(b));
            end
            3'd5, 3'd6: begin
                e.inv = sn;
                if (na && nb) begin e.m = QNAN_C; e.tag = boxed ? "R9" : "R2"; end
                else if (na) begin e.m = b; e.tag = "R9"; end
                else if (nb) begin e.m = a; e.tag = "R9"; end
                else begin
                    bit a_lo = k_mm(a) < k_mm(b);
                    e.m = (op == 5) ? (a_lo ? a : b) : (a_lo ? b : a);
                    e.tag = (a[30:0] == 0 && b[30:0] == 0) ? "R10" : "R11";
                end
            end
            default: e.tag = "R4";
        endcase
        return e;
    endfunction

    task automatic check_now();
        exp_t e;
        if (exp_q.size() == 0) return;
        e = exp_q.pop_front();
        n_cmp++;
        if (valid_out !== e.v || cmp_res !== e.r || mm_res !== e.m || invalid !== e.inv) begin
            n_bad++;
            $display("FAIL %s R8: got v=%0b r=%h m=%h inv=%0b exp v=%0b r=%h m=%h inv=%0b",
                     e.tag, valid_out, cmp_res, mm_res, invalid, e.v, e.r, e.m, e.inv);
        end
    endtask

    task automatic step(input logic v, input logic [2:0] op, input logic [63:0] a, input logic [63:0] b);
        @(negedge clk);
        check_now();
        valid_in = v; op_i = op; opa_i = a; opb_i = b;
        exp_q.push_back(model(v, op, a, b));
    endtask

    function automatic logic [31:0] pick();
        return ($urandom_range(0, 2) == 0) ? specials[$urandom_range(0, 11)] : $urandom;
    endfunction

    initial begin
        #2_000_000;
        if (!done) begin
            n_bad++;
            $display("FAIL R1: watchdog expired, got hang exp completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        exp_t rz;
        repeat (3) @(negedge clk);
        // reset state check (R1)
        rz.v = 0; rz.r = 0; rz.m = 0; rz.inv = 0; rz.tag = "R1";
        valid_in = 1'b1; op_i = 3'd5; opa_i = '1; opb_i = '1;
        exp_q.push_back(rz);
        @(negedge clk);
        check_now();
        rst_n = 1'b1; valid_in = 1'b0;
        // directed: every opcode (R4) against all special pairs
        for (int op = 0; op < 8; op++)
            for (int i = 0; i < 12; i++)
                for (int j = 0; j < 12; j++)
                    step(1'b1, 3'(op), {32'hFFFF_FFFF, specials[i]}, {32'hFFFF_FFFF, specials[j]});
        // idle cycles with junk inputs (R1)
        for (int i = 0; i < 20; i++) step(1'b0, 3'(i), {$urandom, $urandom}, {$urandom, $urandom});
        // mis-boxed operands (R2)
        for (int op = 0; op < 8; op++)
            for (int i = 0; i < 12; i++) begin
                step(1'b1, 3'(op), {32'h0000_0000, specials[i]}, {32'hFFFF_FFFF, specials[i]});
                step(1'b1, 3'(op), {32'hFFFF_FFFF, specials[i]}, {32'hFFFF_FFFE, specials[i]});
                step(1'b1, 3'(op), {32'h7FFF_FFFF, specials[i]}, {32'h1234_5678, specials[i]});
            end
        // random pairs, mixed boxing and gaps
        for (int n = 0; n < 4000; n++) begin
            logic [31:0] ha = ($urandom_range(0, 9) == 0) ? $urandom : 32'hFFFF_FFFF;
            logic [31:0] hb = ($urandom_range(0, 9) == 0) ? $urandom : 32'hFFFF_FFFF;
            step($urandom_range(0, 7) != 0, 3'($urandom_range(0, 7)), {ha, pick()}, {hb, pick()});
        end
        step(1'b0, 3'd0, 64'd0, 64'd0);
        step(1'b0, 3'd0, 64'd0, 64'd0);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule